// File: doc/BRIEF.md
# Two-way write-through burst cache

This block is a second-level cache controller placed between a processor-side burst bus and a slower main-memory port. Storage is two-way set-associative. Each line holds four 32-bit doublewords. Every access compares the tags of both ways in the addressed set. A read that hits returns the whole line as a burst with 2-1-1-1 beat timing. A read that misses fetches the line from memory. Each returned doubleword goes to the processor in the same cycle that it is written into the chosen way.

Writes always pass through to memory. A write that hits also updates the cached doubleword. A write that misses allocates nothing. Each set keeps one replacement bit. The controller handles one transaction at a time: it takes no new request until the current burst or write-through has finished.

Addresses are byte addresses, split into three fields:
- Bits 1:0 are not used for ordering.
- Bits 3:2 select the doubleword within the line.
- The next log2(SETS) bits select the set.
- The remaining upper bits are the tag.

Top module: `wt_burst_cache`

## Requirements
- R1: After reset, `cpu_rdy_o` is high, `cpu_rvalid_o` and `mem_req_o` are low, and every line is invalid, so the first read of any address misses.
- R2: If a read that hits is accepted on clock edge k, exactly four beats are presented with `cpu_rvalid_o` high in the cycles that follow edges k+1, k+2, k+3 and k+4, and `mem_req_o` stays low.
- R3: Doubleword bits 3:2 select the word in a line, the next log2(SETS) bits select the set, and the rest form the tag. Beats always carry doublewords 0, 1, 2, 3 of the line in that order, whatever address bits 3:2 the request carries.
- R4: A read miss raises `mem_req_o` with `mem_we_o` low and `mem_addr_o` line-aligned (bits 3:0 zero). Each cycle with `mem_rvalid_i` high forwards that word on `cpu_rdata_o` with `cpu_rvalid_o` high in the same cycle, for four beats.
- R5: A line becomes valid once all four fill beats are written. Later reads of it hit and return the filled data.
- R6: Two lines with different tags and the same set index can be resident at the same time.
- R7: A miss fill replaces an invalid way if one exists, otherwise the least recently used way. Every read hit, write hit or completed fill makes the way it used the most recent.
- R8: A write that hits replaces the addressed doubleword in the cache, and a later read hit returns the new value.
- R9: A write that misses changes neither the cached lines nor the replacement state. A later read of that line misses.
- R10: Every write raises `mem_req_o` with `mem_we_o` high, with the exact request address and data, held stable until `mem_wack_i`. No read beats occur during a write.
- R11: `cpu_rdy_o` is low from the acceptance edge until the last read beat or the write acknowledge. Requests presented while it is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, taken when `cpu_rdy_o` is high |
| cpu_we_i | input | 1 | Request is a write |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_wdata_i | input | DATA_W | Write doubleword |
| cpu_rdy_o | output | 1 | Controller idle and able to accept a request |
| cpu_rvalid_o | output | 1 | Read beat valid |
| cpu_rdata_o | output | DATA_W | Read beat data |
| mem_req_o | output | 1 | Memory transaction active |
| mem_we_o | output | 1 | Memory transaction is a write |
| mem_addr_o | output | ADDR_W | Memory byte address (line-aligned for reads) |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rvalid_i | input | 1 | Memory read beat valid |
| mem_rdata_i | input | DATA_W | Memory read beat data |
| mem_wack_i | input | 1 | Memory write accepted |

## Verification
During a miss, forwarding a doubleword to the processor and writing it into the selected way happen in the same cycle. The bench provokes this with read misses in every set, using a memory model that inserts a gap between the second and third beats. In each fill cycle it compares the forwarded word with the memory word, and it then reads the same line again and expects a hit with that data. A write hit is handled the same way: the cache update is judged by a later read hit, and the write-through is judged at the memory port.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int unsigned WAYS       = 2;
  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned WSEL_W     = $clog2(LINE_WORDS);
  localparam int unsigned LINE_OFS_W = WSEL_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_HIT,
    ST_FILL,
    ST_WRITE
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_array.sv
module wtc_tag_array import wtc_pkg::*; #(
  parameter int unsigned SETS  = 4,
  parameter int unsigned IDX_W = $clog2(SETS),
  parameter int unsigned TAG_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [WAYS-1:0]  hit_o,
  output logic             victim_o,
  input  logic             inval_i,
  input  logic             inval_way_i,
  input  logic             touch_i,
  input  logic             touch_way_i,
  input  logic             fill_i,
  input  logic             fill_way_i
);
  logic [WAYS-1:0] vld_w;
  logic [SETS-1:0] lru_q;  // per set: way to evict next

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
      end else if (fill_i && fill_way_i == 1'(w)) begin
        valid_q[idx_i] <= 1'b1;
      end else if (inval_i && inval_way_i == 1'(w)) begin
        valid_q[idx_i] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (fill_i && fill_way_i == 1'(w)) tag_q[idx_i] <= tag_i;
    end

    assign vld_w[w] = valid_q[idx_i];
    assign hit_o[w] = valid_q[idx_i] && (tag_q[idx_i] == tag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lru_q <= '0;
    end else if (fill_i) begin
      lru_q[idx_i] <= ~fill_way_i;
    end else if (touch_i) begin
      lru_q[idx_i] <= ~touch_way_i;
    end
  end

  always_comb begin
    if (!vld_w[0])      victim_o = 1'b0;
    else if (!vld_w[1]) victim_o = 1'b1;
    else                victim_o = lru_q[idx_i];
  end
endmodule

// File: rtl/wtc_data_array.sv
module wtc_data_array import wtc_pkg::*; #(
  parameter int unsigned SETS   = 4,
  parameter int unsigned IDX_W  = $clog2(SETS),
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              wway_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [WSEL_W-1:0] wword_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rway_i,
  input  logic [IDX_W-1:0]  ridx_i,
  input  logic [WSEL_W-1:0] rword_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = WAYS * SETS * LINE_WORDS;
  localparam int unsigned AW    = 1 + IDX_W + WSEL_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     waddr, raddr;

  assign waddr = {wway_i, widx_i, wword_i};
  assign raddr = {rway_i, ridx_i, rword_i};

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl import wtc_pkg::*; #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned TAG_W  = ADDR_W - IDX_W - LINE_OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_rdy_o,
  output logic              cpu_rvalid_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_wack_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o,
  input  logic [WAYS-1:0]   hit_i,
  input  logic              victim_i,
  output logic              inval_o,
  output logic              inval_way_o,
  output logic              touch_o,
  output logic              touch_way_o,
  output logic              fill_o,
  output logic              fill_way_o,
  output logic              dwe_o,
  output logic              dway_o,
  output logic [WSEL_W-1:0] dword_o,
  output logic [DATA_W-1:0] dwdata_o,
  output logic              rway_o,
  output logic [WSEL_W-1:0] rword_o,
  input  logic [DATA_W-1:0] rdata_i
);
  wtc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q, way_q, way_d;
  logic [WSEL_W-1:0] beat_q, beat_d;
  logic              any_hit, hit_way, last_beat;

  assign idx_o     = addr_q[LINE_OFS_W +: IDX_W];
  assign tag_o     = addr_q[ADDR_W-1 -: TAG_W];
  assign any_hit   = |hit_i;
  assign hit_way   = hit_i[1];
  assign last_beat = (beat_q == WSEL_W'(LINE_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      way_q   <= 1'b0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      way_q   <= way_d;
      beat_q  <= beat_d;
      if (state_q == ST_IDLE && cpu_req_i) begin
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
        we_q    <= cpu_we_i;
      end
    end
  end

  always_comb begin
    state_d      = state_q;
    way_d        = way_q;
    beat_d       = beat_q;
    cpu_rdy_o    = 1'b0;
    cpu_rvalid_o = 1'b0;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    inval_o      = 1'b0;
    inval_way_o  = victim_i;
    touch_o      = 1'b0;
    touch_way_o  = hit_way;
    fill_o       = 1'b0;
    fill_way_o   = way_q;
    dwe_o        = 1'b0;
    dway_o       = way_q;
    dword_o      = beat_q;
    dwdata_o     = mem_rdata_i;
    unique case (state_q)
      ST_IDLE: begin
        cpu_rdy_o = 1'b1;
        if (cpu_req_i) state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        beat_d = '0;
        if (any_hit) begin
          touch_o = 1'b1;
          way_d   = hit_way;
          if (we_q) begin
            dwe_o    = 1'b1;
            dway_o   = hit_way;
            dword_o  = addr_q[2 +: WSEL_W];
            dwdata_o = wdata_q;
            state_d  = ST_WRITE;
          end else begin
            state_d = ST_HIT;
          end
        end else if (we_q) begin
          state_d = ST_WRITE;  // no allocation on write miss
        end else begin
          inval_o = 1'b1;      // victim stays invalid until the fill completes
          way_d   = victim_i;
          state_d = ST_FILL;
        end
      end
      ST_HIT: begin
        cpu_rvalid_o = 1'b1;
        beat_d       = beat_q + 1'b1;
        if (last_beat) state_d = ST_IDLE;
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_rvalid_i) begin
          cpu_rvalid_o = 1'b1;
          dwe_o        = 1'b1;
          beat_d       = beat_q + 1'b1;
          if (last_beat) begin
            fill_o  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_wack_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rway_o      = way_q;
  assign rword_o     = beat_q;
  assign cpu_rdata_o = (state_q == ST_FILL) ? mem_rdata_i : rdata_i;
  assign mem_addr_o  = we_q ? addr_q : {addr_q[ADDR_W-1:LINE_OFS_W], {LINE_OFS_W{1'b0}}};
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/wt_burst_cache.sv
module wt_burst_cache import wtc_pkg::*; #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SETS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_rdy_o,
  output logic              cpu_rvalid_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_wack_i
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - LINE_OFS_W;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WAYS-1:0]   hit;
  logic              victim, inval, inval_way, touch, touch_way, fill, fill_way;
  logic              dwe, dway, rway;
  logic [WSEL_W-1:0] dword, rword;
  logic [DATA_W-1:0] dwdata, rdata;

  wtc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_rdy_o, .cpu_rvalid_o, .cpu_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rvalid_i, .mem_rdata_i, .mem_wack_i,
    .idx_o(idx), .tag_o(tag), .hit_i(hit), .victim_i(victim),
    .inval_o(inval), .inval_way_o(inval_way),
    .touch_o(touch), .touch_way_o(touch_way),
    .fill_o(fill), .fill_way_o(fill_way),
    .dwe_o(dwe), .dway_o(dway), .dword_o(dword), .dwdata_o(dwdata),
    .rway_o(rway), .rword_o(rword), .rdata_i(rdata)
  );

  wtc_tag_array #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i, .rst_ni,
    .idx_i(idx), .tag_i(tag), .hit_o(hit), .victim_o(victim),
    .inval_i(inval), .inval_way_i(inval_way),
    .touch_i(touch), .touch_way_i(touch_way),
    .fill_i(fill), .fill_way_i(fill_way)
  );

  wtc_data_array #(
    .SETS(SETS), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_data (
    .clk_i,
    .we_i(dwe), .wway_i(dway), .widx_i(idx), .wword_i(dword), .wdata_i(dwdata),
    .rway_i(rway), .ridx_i(idx), .rword_i(rword), .rdata_o(rdata)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_rdy_o,
  input logic              cpu_rvalid_o,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              mem_wack_i
);
  logic [2:0] beats_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           beats_q <= '0;
    else if (cpu_rdy_o)    beats_q <= '0;
    else if (cpu_rvalid_o) beats_q <= beats_q + 3'd1;
  end

  a_r2_four_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rdy_o |-> (beats_q == 3'd0 || beats_q == 3'd4));

  a_r2_gapless_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rvalid_o && !mem_req_o && beats_q < 3'd3) |=> cpu_rvalid_o);

  a_r4_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_rvalid_i) |-> (cpu_rvalid_o && cpu_rdata_o == mem_rdata_i));

  a_r4_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o[3:0] == 4'd0));

  a_r10_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_wack_i) |=> (mem_req_o && mem_we_o && $stable(mem_addr_o)));

  a_r10_no_beats_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !cpu_rvalid_o);

  a_r11_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rvalid_o || mem_req_o) |-> !cpu_rdy_o);
endmodule

bind wt_burst_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_wt_burst_cache.sv
`timescale 1ns/1ps
module tb_wt_burst_cache;
  localparam int SETS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic        cpu_rdy_o, cpu_rvalid_o, mem_req_o, mem_we_o;
  logic [31:0] cpu_rdata_o, mem_wdata_o;
  logic [15:0] mem_addr_o;
  logic        mem_rvalid_i, mem_wack_i;
  logic [31:0] mem_rdata_i;

  logic [31:0] mem [16384];
  int cyc = 0;
  int n_tests = 0, n_fail = 0;

  bit         mv [2][SETS];
  logic [9:0] mt [2][SETS];
  bit         ml [SETS];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wt_burst_cache #(.ADDR_W(16), .DATA_W(32), .SETS(SETS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_rdy_o, .cpu_rvalid_o, .cpu_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rvalid_i, .mem_rdata_i, .mem_wack_i
  );

  // memory model: 2-cycle first latency, one idle cycle after beat 2, write ack after 3 cycles
  initial begin
    int rbeat, rlat, wlat;
    for (int i = 0; i < 16384; i++) mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h3C00_0000;
    mem_rvalid_i = 1'b0; mem_rdata_i = '0; mem_wack_i = 1'b0;
    rbeat = 0; rlat = 2; wlat = 3;
    forever begin
      @(posedge clk); #1;
      if (rst_n && mem_req_o && !mem_we_o) begin
        if (rlat > 0) begin
          rlat--; mem_rvalid_i = 1'b0;
        end else begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem[{mem_addr_o[15:4], 2'(rbeat)}];
          rbeat++;
          if (rbeat == 2) rlat = 1;
        end
      end else if (rst_n && mem_req_o && mem_we_o) begin
        if (wlat > 0) begin
          wlat--; mem_wack_i = 1'b0;
        end else begin
          mem_wack_i = 1'b1;
          mem[mem_addr_o[15:2]] = mem_wdata_o;
        end
      end else begin
        mem_rvalid_i = 1'b0; mem_wack_i = 1'b0;
        rbeat = 0; rlat = 2; wlat = 3;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int t, input int s, input int w);
    return {10'(t), 2'(s), 2'(w), 2'b00};
  endfunction

  function automatic int mlook(input logic [15:0] a);
    for (int w = 0; w < 2; w++)
      if (mv[w][a[5:4]] && mt[w][a[5:4]] == a[15:6]) return w;
    return -1;
  endfunction

  task automatic do_read(input logic [15:0] a, input bit noise, input string rq);
    int hw, nb, acc, idx, v, lw;
    int offs [4];
    logic [31:0] dat [4];
    bit saw_miss, fwd_ok, algn_ok, idle_ok;
    idx = int'(a[5:4]);
    lw  = int'({a[15:4], 2'b00});
    hw  = mlook(a);
    nb = 0; saw_miss = 0; fwd_ok = 1; algn_ok = 1;
    for (int i = 0; i < 4; i++) begin offs[i] = 0; dat[i] = '0; end
    while (!cpu_rdy_o) @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = a;
    @(posedge clk); #1;
    acc = cyc;
    cpu_req_i = 1'b0;
    if (noise) begin
      cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_addr_i = a ^ 16'h0440; cpu_wdata_i = 32'hDEAD_BEEF;
    end
    do begin
      @(negedge clk);
      if (mem_req_o && !mem_we_o) begin
        saw_miss = 1;
        if (mem_addr_o != {a[15:4], 4'h0}) algn_ok = 0;
        if (cpu_rvalid_o != mem_rvalid_i) fwd_ok = 0;
        if (mem_rvalid_i && cpu_rdata_o != mem_rdata_i) fwd_ok = 0;
      end
      if (cpu_rvalid_o) begin
        if (nb < 4) begin offs[nb] = cyc - acc; dat[nb] = cpu_rdata_o; end
        nb++;
      end
    end while (!cpu_rdy_o);
    cpu_req_i = 1'b0; cpu_we_i = 1'b0;

    chk(saw_miss == (hw < 0), rq, "miss indication", 32'(saw_miss), 32'(hw < 0));
    chk(nb == 4, (hw < 0) ? "R4" : "R2", "beat count", 32'(nb), 32'd4);
    for (int i = 0; i < 4; i++)
      chk(dat[i] == mem[lw + i], "R3", "beat data in order", dat[i], mem[lw + i]);
    if (hw >= 0) begin
      for (int i = 0; i < 4; i++)
        chk(offs[i] == i + 1, "R2", "beat cycle offset", 32'(offs[i]), 32'(i + 1));
    end else begin
      chk(fwd_ok, "R4", "same-cycle forward", 32'(fwd_ok), 32'd1);
      chk(algn_ok, "R4", "line-aligned fetch address", 32'(algn_ok), 32'd1);
    end
    if (noise) begin
      idle_ok = 1;
      repeat (4) begin
        @(negedge clk);
        if (!cpu_rdy_o || mem_req_o || cpu_rvalid_o) idle_ok = 0;
      end
      chk(idle_ok, "R11", "request during busy ignored", 32'(idle_ok), 32'd1);
    end
    // reference replacement model
    if (hw >= 0) begin
      ml[idx] = (hw == 0);
    end else begin
      v = !mv[0][idx] ? 0 : (!mv[1][idx] ? 1 : int'(ml[idx]));
      mv[v][idx] = 1; mt[v][idx] = a[15:6]; ml[idx] = (v == 0);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    int hw;
    bit saw, bad, rv;
    hw = mlook(a);
    saw = 0; bad = 0; rv = 0;
    while (!cpu_rdy_o) @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_addr_i = a; cpu_wdata_i = d;
    @(posedge clk); #1;
    cpu_req_i = 1'b0; cpu_we_i = 1'b0;
    do begin
      @(negedge clk);
      if (mem_req_o && mem_we_o) begin
        saw = 1;
        if (mem_addr_o != a || mem_wdata_o != d) bad = 1;
      end
      if (cpu_rvalid_o) rv = 1;
    end while (!cpu_rdy_o);
    chk(saw, "R10", "write reaches memory", 32'(saw), 32'd1);
    chk(!bad, "R10", "write address/data", 32'(bad), 32'd0);
    chk(!rv, "R10", "no read beats during write", 32'(rv), 32'd0);
    chk(mem[a[15:2]] == d, "R10", "memory word after ack", mem[a[15:2]], d);
    if (hw >= 0) ml[a[5:4]] = (hw == 0);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin mv[0][s] = 0; mv[1][s] = 0; ml[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_rdy_o == 1'b1, "R1", "ready after reset", 32'(cpu_rdy_o), 32'd1);
    chk(cpu_rvalid_o == 1'b0, "R1", "no beat after reset", 32'(cpu_rvalid_o), 32'd0);
    chk(mem_req_o == 1'b0, "R1", "no memory request after reset", 32'(mem_req_o), 32'd0);

    // fills of two tags per set, then hits at every word offset
    for (int s = 0; s < SETS; s++) begin
      do_read(mk(s + 1, s, s % 4), 0, (s == 0) ? "R1" : "R5");
      do_read(mk(s + 5, s, (s + 1) % 4), 0, "R6");
      for (int w = 0; w < 4; w++) begin
        do_read(mk(s + 1, s, w), 0, "R5");
        do_read(mk(s + 5, s, 3 - w), 0, "R6");
      end
    end

    // replacement order
    for (int s = 0; s < SETS; s++) begin
      do_read(mk(s + 1, s, 0), 0, "R7");
      do_read(mk(s + 9, s, 1), 0, "R7");
      do_read(mk(s + 1, s, 2), 0, "R7");
      do_read(mk(s + 5, s, 3), 0, "R7");
      do_read(mk(s + 9, s, 0), 0, "R7");
    end

    // write hit, write miss
    for (int s = 0; s < SETS; s++) begin
      int t0, t1;
      t0 = int'(mt[0][s]); t1 = int'(mt[1][s]);
      do_write(mk(t1, s, (s + 2) % 4), 32'hA500_0000 | 32'(s << 8) | 32'(s));
      do_read(mk(t1, s, 0), 0, "R8");
      do_read(mk(t0, s, 1), 0, "R8");
      do_write(mk(s + 13, s, 1), 32'h5A00_0000 | 32'(s));
      do_read(mk(s + 13, s, 3), 0, "R9");
      do_read(mk(t0, s, 2), 0, "R9");
    end

    // requests held while busy
    do_read(mk(2, 1, 2), 1, "R11");
    do_read(mk(20, 2, 1), 1, "R11");
    do_read(mk(20, 2, 0), 1, "R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule